// File: doc/BRIEF.md
# Floating-Point Block Transfer Sequencer

This block turns one floating-point load-multiple or store-multiple command into a stream of word-sized memory micro-ops. An optional base-register update follows them. A command gives the base register, the first data register, a precision flag (single or double), an ascending/descending flag, a writeback flag, a load/store flag and an 8-bit offset field. The block accepts a command when it is idle. It then issues one micro-op per cycle over a valid/ready handshake. Each micro-op has a kind, a register index, an unsigned displacement, a direction bit and two flag bits.

Displacements are always unsigned. A descending walk starts at four times the offset field and counts down. If the running displacement would reach zero or go below it, the walk switches to ascending and negates the value. A double-precision register is issued as two word accesses: the lower word first, then the upper word. The block does not access memory or write registers. A warning output marks a command whose offset field gives an unusable register count.

Top module: `fpx_blk_seq`

## Requirements
- R1: The register count is the offset field for single precision (cmd_dbl=0). For double precision (cmd_dbl=1) it is the offset field shifted right by one, so an odd field rounds down.
- R2: warn is high for the whole sequence of a command whose register count is zero or greater than REG_LIMIT (default 32). A count above the limit is clamped to REG_LIMIT. A count equal to the limit does not warn.
- R3: A register count of zero forces writeback. Such a command issues exactly one micro-op, the base update.
- R4: A command issues exactly count×1 (single) or count×2 (double) memory micro-ops, plus one base update when writeback is in effect, and nothing more.
- R5: An ascending walk (cmd_up=1) starts at displacement 0. It adds 4 per word, and every memory micro-op has uop_up=1.
- R6: A descending walk (cmd_up=0) starts at 4×offset field with uop_up=0. It subtracts 4 per word (8 per double register). The running displacement never becomes negative: at zero or below it switches to ascending with the value negated.
- R7: For double precision, each register issues a lower-word access at the current displacement, then an upper-word access at that displacement +4 (ascending) or −4 (descending). uop_reg starts at cmd_first and increases by one for every memory micro-op, modulo 2^REG_W.
- R8: The base update comes after all memory micro-ops. It has uop_kind=2, uop_reg=cmd_base, uop_disp=4×offset field, and uop_up equal to cmd_up (1 adds, 0 subtracts).
- R9: uop_flags[0] (last) is set only on the final micro-op of a command. uop_flags[1] (delayed commit) is set on every earlier one. After the last one is taken, uop_valid drops.
- R10: cmd_ready is high only when no sequence is in progress. An accepted command presents its first micro-op on the next cycle. While uop_valid is high and uop_ready is low, all micro-op outputs hold.
- R11: Memory micro-ops have uop_kind=0 when cmd_load=1 and uop_kind=1 when cmd_load=0.
- R12: After reset, uop_valid=0, cmd_ready=1 and warn=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_base | input | BASE_W (4) | Base register index |
| cmd_first | input | REG_W (7) | First data register (word index) |
| cmd_dbl | input | 1 | 1 = double precision |
| cmd_up | input | 1 | 1 = ascending, 0 = descending |
| cmd_wb | input | 1 | Request base update |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_off | input | OFF_W (8) | Offset field |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes micro-op |
| uop_kind | output | 2 | 0 load word, 1 store word, 2 base update |
| uop_reg | output | REG_W (7) | Register index |
| uop_disp | output | OFF_W+2 (10) | Unsigned displacement |
| uop_up | output | 1 | Direction: 1 add, 0 subtract |
| uop_flags | output | 2 | [0] last, [1] delayed commit |
| warn | output | 1 | Offset field of current command invalid |

## Verification
On every cycle, assertions check these rules: the running displacement never goes negative, micro-op outputs hold while stalled, the register index steps by one between memory micro-ops, the base update is always last, uop_valid drops after the last micro-op is taken, and an accepted command produces a micro-op on the next cycle. Only the bench's scenarios can show the values themselves. These include the displacement sequence for each mix of precision and direction, rounding of an odd double offset field, clamping and warning at and beyond the register limit, and the forced base update on a zero count. They also include the total micro-op count, which is checked by confirming the block goes idle right after the expected final micro-op.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    UOP_LOAD  = 2'd0,
    UOP_STORE = 2'd1,
    UOP_BASE  = 2'd2
  } uop_kind_e;

  localparam int FLAG_LAST  = 0;
  localparam int FLAG_DELAY = 1;
endpackage

// File: rtl/fpx_cmd_decode.sv
module fpx_cmd_decode #(
  parameter int REG_LIMIT = 32,
  parameter int OFF_W     = 8,
  parameter int CNT_W     = 7,
  parameter int DISP_W    = 10
) (
  input  logic [OFF_W-1:0]  off,
  input  logic              dbl,
  input  logic              up,
  input  logic              wb_req,
  output logic [CNT_W-1:0]  words,
  output logic              wb_eff,
  output logic              bad,
  output logic [DISP_W-1:0] init_disp
);
  localparam logic [OFF_W:0]   LIM_O = REG_LIMIT[OFF_W:0];
  localparam logic [CNT_W-1:0] LIM_C = REG_LIMIT[CNT_W-1:0];

  logic [OFF_W-1:0] raw;
  logic             over;
  logic             zero;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    raw       = dbl ? (off >> 1) : off;
    over      = {1'b0, raw} > LIM_O;
    zero      = (raw == '0);
    cnt       = over ? LIM_C : CNT_W'(raw);
    words     = dbl ? (cnt << 1) : cnt;
    wb_eff    = wb_req | zero;
    bad       = over | zero;
    init_disp = up ? '0 : {off, 2'b00};
  end
endmodule

// File: rtl/fpx_disp_walker.sv
module fpx_disp_walker #(
  parameter int DISP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DISP_W-1:0] init_disp,
  input  logic              init_up,
  input  logic              dbl,
  input  logic              adv,
  output logic [DISP_W-1:0] disp_out,
  output logic              dir_out
);
  localparam int SW = DISP_W + 1;

  logic signed [SW-1:0] run_q, run_d;
  logic                 dir_q, dir_d;
  logic                 top_q, top_d;
  logic signed [SW-1:0] step;
  logic signed [SW-1:0] nxt;
  logic signed [SW-1:0] word_disp;

  always_comb begin
    step = dbl ? SW'(8) : SW'(4);
    nxt  = run_q - step;
    if (dbl && top_q)
      word_disp = dir_q ? (run_q + SW'(4)) : (run_q - SW'(4));
    else
      word_disp = run_q;
    disp_out = word_disp[DISP_W-1:0];
    dir_out  = dir_q;
  end

  always_comb begin
    run_d = run_q;
    dir_d = dir_q;
    top_d = top_q;
    if (start) begin
      run_d = $signed({1'b0, init_disp});
      dir_d = init_up;
      top_d = 1'b0;
    end else if (adv) begin
      if (dbl && !top_q) begin
        top_d = 1'b1;
      end else begin
        top_d = 1'b0;
        if (dir_q) begin
          run_d = run_q + step;
        end else if (nxt <= 0) begin
          dir_d = 1'b1;
          run_d = -nxt;
        end else begin
          run_d = nxt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      dir_q <= 1'b1;
      top_q <= 1'b0;
    end else if (start || adv) begin
      run_q <= run_d;
      dir_q <= dir_d;
      top_q <= top_d;
    end
  end

  AST_RUN_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q[SW-1]); // R6
endmodule

// File: rtl/fpx_seq_ctrl.sv
module fpx_seq_ctrl #(
  parameter int CNT_W = 7,
  parameter int REG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CNT_W-1:0] words,
  input  logic             wb_eff,
  input  logic [REG_W-1:0] first_reg,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic             fire,
  output logic             is_mem,
  output logic             last,
  output logic [REG_W-1:0] reg_idx
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             wb_q, wb_d;
  logic [REG_W-1:0] reg_q, reg_d;
  logic             accept;

  always_comb begin
    cmd_ready = !busy_q;
    accept    = cmd_valid && !busy_q;
    uop_valid = busy_q;
    fire      = busy_q && uop_ready;
    is_mem    = (left_q != '0);
    last      = is_mem ? ((left_q == CNT_W'(1)) && !wb_q) : 1'b1;
    reg_idx   = reg_q;
  end

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    wb_d   = wb_q;
    reg_d  = reg_q;
    if (accept) begin
      busy_d = 1'b1;
      left_d = words;
      wb_d   = wb_eff;
      reg_d  = first_reg;
    end else if (fire) begin
      if (is_mem) begin
        left_d = left_q - CNT_W'(1);
        reg_d  = reg_q + REG_W'(1);
      end
      if (last)
        busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      wb_q   <= 1'b0;
      reg_q  <= '0;
    end else if (accept || fire) begin
      busy_q <= busy_d;
      left_q <= left_d;
      wb_q   <= wb_d;
      reg_q  <= reg_d;
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> uop_valid); // R10
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> !uop_valid); // R9
endmodule

// File: rtl/fpx_blk_seq.sv
module fpx_blk_seq
  import fpx_pkg::*;
#(
  parameter int REG_LIMIT = 32,
  parameter int OFF_W     = 8,
  parameter int REG_W     = 7,
  parameter int BASE_W    = 4,
  localparam int CNT_W    = $clog2(2 * REG_LIMIT + 1),
  localparam int DISP_W   = OFF_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BASE_W-1:0] cmd_base,
  input  logic [REG_W-1:0]  cmd_first,
  input  logic              cmd_dbl,
  input  logic              cmd_up,
  input  logic              cmd_wb,
  input  logic              cmd_load,
  input  logic [OFF_W-1:0]  cmd_off,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [1:0]        uop_kind,
  output logic [REG_W-1:0]  uop_reg,
  output logic [DISP_W-1:0] uop_disp,
  output logic              uop_up,
  output logic [1:0]        uop_flags,
  output logic              warn
);
  logic [CNT_W-1:0]  dec_words;
  logic              dec_wb;
  logic              dec_bad;
  logic [DISP_W-1:0] dec_init;

  logic              accept;
  logic              fire;
  logic              is_mem;
  logic              last;
  logic [REG_W-1:0]  mem_reg;
  logic [DISP_W-1:0] mem_disp;
  logic              mem_dir;

  logic [BASE_W-1:0] base_q, base_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              dbl_q, dbl_d;
  logic              up_q, up_d;
  logic              load_q, load_d;
  logic              warn_q, warn_d;
  uop_kind_e         kind;

  fpx_cmd_decode #(
    .REG_LIMIT(REG_LIMIT), .OFF_W(OFF_W), .CNT_W(CNT_W), .DISP_W(DISP_W)
  ) u_dec (
    .off(cmd_off), .dbl(cmd_dbl), .up(cmd_up), .wb_req(cmd_wb),
    .words(dec_words), .wb_eff(dec_wb), .bad(dec_bad), .init_disp(dec_init)
  );

  fpx_seq_ctrl #(.CNT_W(CNT_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .words(dec_words), .wb_eff(dec_wb), .first_reg(cmd_first),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .fire(fire),
    .is_mem(is_mem), .last(last), .reg_idx(mem_reg)
  );

  assign accept = cmd_valid && cmd_ready;

  fpx_disp_walker #(.DISP_W(DISP_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(accept), .init_disp(dec_init),
    .init_up(cmd_up), .dbl(dbl_q), .adv(fire && is_mem),
    .disp_out(mem_disp), .dir_out(mem_dir)
  );

  always_comb begin
    base_d = accept ? cmd_base : base_q;
    off_d  = accept ? cmd_off  : off_q;
    dbl_d  = accept ? cmd_dbl  : dbl_q;
    up_d   = accept ? cmd_up   : up_q;
    load_d = accept ? cmd_load : load_q;
    warn_d = accept ? dec_bad  : warn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      dbl_q  <= 1'b0;
      up_q   <= 1'b1;
      load_q <= 1'b0;
      warn_q <= 1'b0;
    end else if (accept) begin
      base_q <= base_d;
      off_q  <= off_d;
      dbl_q  <= dbl_d;
      up_q   <= up_d;
      load_q <= load_d;
      warn_q <= warn_d;
    end
  end

  always_comb begin
    if (!is_mem)     kind = UOP_BASE;
    else if (load_q) kind = UOP_LOAD;
    else             kind = UOP_STORE;
    uop_kind              = kind;
    uop_reg               = is_mem ? mem_reg : REG_W'(base_q);
    uop_disp              = is_mem ? mem_disp : {off_q, 2'b00};
    uop_up                = is_mem ? mem_dir : up_q;
    uop_flags[FLAG_LAST]  = last;
    uop_flags[FLAG_DELAY] = !last;
    warn                  = warn_q;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_kind) &&
      $stable(uop_reg) && $stable(uop_disp) && $stable(uop_up) &&
      $stable(uop_flags))); // R10
  AST_BASE_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == 2'd2) |-> uop_flags[FLAG_LAST]); // R8
  AST_REG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_ready && uop_kind != 2'd2 && !uop_flags[FLAG_LAST])
      |=> (uop_kind == 2'd2 ||
           uop_reg == REG_W'($past(uop_reg) + REG_W'(1)))); // R7
endmodule

// File: tb/fpx_blk_seq_test.sv
module fpx_blk_seq_test;
  localparam int REG_W  = 7;
  localparam int OFF_W  = 8;
  localparam int BASE_W = 4;
  localparam int DISP_W = 10;
  localparam int LIMIT  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [BASE_W-1:0] cmd_base = '0;
  logic [REG_W-1:0]  cmd_first = '0;
  logic              cmd_dbl = 1'b0;
  logic              cmd_up = 1'b1;
  logic              cmd_wb = 1'b0;
  logic              cmd_load = 1'b0;
  logic [OFF_W-1:0]  cmd_off = '0;
  logic              uop_valid;
  logic              uop_ready = 1'b0;
  logic [1:0]        uop_kind;
  logic [REG_W-1:0]  uop_reg;
  logic [DISP_W-1:0] uop_disp;
  logic              uop_up;
  logic [1:0]        uop_flags;
  logic              warn;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fpx_blk_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_first(cmd_first), .cmd_dbl(cmd_dbl),
    .cmd_up(cmd_up), .cmd_wb(cmd_wb), .cmd_load(cmd_load), .cmd_off(cmd_off),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_kind(uop_kind),
    .uop_reg(uop_reg), .uop_disp(uop_disp), .uop_up(uop_up),
    .uop_flags(uop_flags), .warn(warn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sends one command, then consumes and checks every micro-op against a
  // model built from the requirements.
  task automatic run_seq(input string req, input int base, input int first,
                         input bit dbl, input bit up, input bit wb,
                         input bit load, input int off, input bit stall);
    int raw, cnt, words, tot, run, step, ed, er, ek, guard;
    bit dir, top, ewarn, ewb, edir, elast;
    logic [21:0] exp_v, act_v, hold_v;
    raw   = dbl ? off / 2 : off;
    ewarn = (raw == 0) || (raw > LIMIT);
    cnt   = (raw > LIMIT) ? LIMIT : raw;
    ewb   = wb || (raw == 0);
    words = dbl ? 2 * cnt : cnt;
    tot   = words + (ewb ? 1 : 0);
    step  = dbl ? 8 : 4;
    run   = up ? 0 : 4 * off;
    dir   = up;
    top   = 1'b0;

    @(negedge clk);
    cmd_base = base[BASE_W-1:0]; cmd_first = first[REG_W-1:0];
    cmd_dbl = dbl; cmd_up = up; cmd_wb = wb; cmd_load = load;
    cmd_off = off[OFF_W-1:0]; cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;

    for (int idx = 0; idx < tot; idx++) begin
      if (idx < words) begin
        ek = load ? 0 : 1;
        er = (first + idx) % 128;
        ed = (dbl && top) ? (dir ? run + 4 : run - 4) : run;
        edir = dir;
        if (dbl && !top) top = 1'b1;
        else begin
          top = 1'b0;
          if (dir) run += step;
          else begin
            run -= step;
            if (run <= 0) begin dir = 1'b1; run = -run; end
          end
        end
      end else begin
        ek = 2; er = base; ed = 4 * off; edir = up;
      end
      elast = (idx == tot - 1);
      exp_v = {ek[1:0], er[REG_W-1:0], ed[DISP_W-1:0], edir, ~elast, elast};

      @(negedge clk);
      guard = 0;
      while (!uop_valid && guard < 20) begin @(negedge clk); guard++; end
      act_v = {uop_kind, uop_reg, uop_disp, uop_up, uop_flags};
      chk(act_v == exp_v, req, $sformatf("uop %0d fields", idx),
          32'(act_v), 32'(exp_v));
      if (idx == 0) begin
        chk(warn == ewarn, "R2", "warn level", 32'(warn), 32'(ewarn));
        chk(cmd_ready == 1'b0, "R10", "cmd_ready while busy",
            32'(cmd_ready), 32'd0);
        if (stall) begin
          hold_v = act_v;
          @(negedge clk);
          @(negedge clk);
          act_v = {uop_kind, uop_reg, uop_disp, uop_up, uop_flags};
          chk(uop_valid && act_v == hold_v, "R10", "hold under stall",
              32'(act_v), 32'(hold_v));
        end
      end
      uop_ready = 1'b1;
      @(posedge clk);
      #1 uop_ready = 1'b0;
    end
    @(negedge clk);
    chk(!uop_valid && cmd_ready, "R4", "idle after final micro-op",
        32'({uop_valid, cmd_ready}), 32'b01);
  endtask

  task automatic t_reset();
    chk(uop_valid == 1'b0, "R12", "uop_valid after reset", 32'(uop_valid), 0);
    chk(cmd_ready == 1'b1, "R12", "cmd_ready after reset", 32'(cmd_ready), 1);
    chk(warn == 1'b0, "R12", "warn after reset", 32'(warn), 0);
  endtask

  task automatic t_single_up();     run_seq("R5 R11", 3, 10, 0, 1, 0, 1, 3, 0); endtask
  task automatic t_single_down_wb(); run_seq("R6 R8", 9, 2, 0, 0, 1, 0, 4, 0); endtask
  task automatic t_double_up_wb();  run_seq("R7 R8", 5, 5, 1, 1, 1, 1, 4, 0); endtask
  task automatic t_double_down();   run_seq("R6 R7", 1, 20, 1, 0, 0, 0, 6, 0); endtask
  task automatic t_odd_double();    run_seq("R1", 2, 0, 1, 1, 0, 1, 5, 0); endtask
  task automatic t_zero_count();    run_seq("R3", 7, 3, 0, 1, 0, 1, 0, 0); endtask
  task automatic t_zero_dbl_down(); run_seq("R3", 4, 3, 1, 0, 0, 0, 1, 0); endtask
  task automatic t_at_limit();      run_seq("R2", 0, 0, 0, 1, 0, 1, 32, 0); endtask
  task automatic t_over_limit();    run_seq("R2", 6, 0, 0, 1, 1, 0, 33, 0); endtask
  task automatic t_over_dbl();      run_seq("R2 R9", 3, 100, 1, 0, 1, 1, 70, 0); endtask
  task automatic t_stall();         run_seq("R10 R9", 8, 40, 1, 1, 1, 0, 2, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_up();
    t_single_down_wb();
    t_double_up_wb();
    t_double_down();
    t_odd_double();
    t_zero_count();
    t_zero_dbl_down();
    t_at_limit();
    t_over_limit();
    t_over_dbl();
    t_stall();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule